// File: doc/BRIEF.md
# Nonvolatile memory write unlock guard

This block sits on a small CPU register bus and decides whether a self-programming operation on nonvolatile memory may start. Software must write a two-byte key to a dedicated key register, 0x55 and then 0xAA, and then set the start bit in the control register. The write-enable bit must already be set when the start bit is written. Only that exact chain of bus writes releases one operation. Any other bus write in the chain throws the key away.

Once an operation is accepted, the block stalls the CPU for the duration of that operation. A per-operation cycle count stands in for the memory array. When the count runs out, the block clears the start bit and pulses a done flag. A start request that arrives without a complete key, with write-enable clear, or with an undefined operation code is dropped, and a sticky error flag is set instead.

Bus register map: address 0 is the control register and address 1 is the key register. Every other address reads as zero.

Top module: `nvm_unlock_guard`

## Requirements
- R1: After reset the control register reads 0x00, stall_o is 0, done_o is 0 and active_op_o is 0.
- R2: Three writes in this order launch an operation: 0x55 to address 1, then 0xAA to address 1, then a write to address 0 with bit 0 (start) set. stall_o must be 1 in the cycle after the start write.
- R3: The two key bytes must be exactly 0x55 and then 0xAA. A wrong byte to address 1 returns the key to empty. A write of 0x55 always counts as a fresh first byte.
- R4: The write-enable bit (control bit 1) must already be 1 before the start write. Setting write-enable and start in the same write is not accepted.
- R5: A start write that is not accepted starts no operation. Control bit 0 reads back 0, and the error flag (control bit 2) becomes 1. A control write leaves the error flag at 1 only if bit 2 of that write is 1. A control write with bit 2 at 0 and bit 0 at 0 clears it.
- R6: Control bits [5:3] select the operation: 0 row erase, 1 latch load, 2 program commit, 3 user-ID commit, 4 EEPROM write. Codes 5 to 7 are rejected as in R5.
- R7: stall_o stays at 1 for exactly the configured cycle count of the selected operation. Control bit 0 reads 1 while the operation runs. done_o is 1 for one cycle, in the first cycle in which stall_o is 0 again, and control bit 0 then reads 0.
- R8: While stall_o is 1, bus writes change neither the control register nor the key. The key is left empty when the operation ends.
- R9: While stall_o is 1, active_op_o shows the code of the running operation. At all other times it reads 0.
- R10: Cycles with no bus write do not break the key chain. Any write to address 0 or to an unused address does break it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_addr_i | input | ADDR_W | Bus write address |
| bus_wdata_i | input | 8 | Bus write data |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Read data, combinational |
| stall_o | output | 1 | CPU stall while an operation runs |
| done_o | output | 1 | One-cycle pulse at operation end |
| active_op_o | output | 3 | Code of the running operation |

## Verification
The bench goes after the following corner cases and the failure each would expose:
- **Key byte sweeps.** It sweeps every value in each key position. A design that compared only some bits of a key byte would launch on a near-miss value.
- **Intruding writes.** It places every kind of intruding write at each point in the chain, and separately inserts idle gaps. A guard that counted cycles instead of writes would fail one of the two.
- **Operation codes and lengths.** It runs all eight operation codes, including a one-cycle operation. This catches off-by-one stall lengths, a misplaced done pulse and codes 5 to 7 slipping through.
- **Write-enable ordering.** It sets write-enable and start in the same write. A design that used the new write-enable value instead of the stored one would accept that start.
- **Writes during busy.** It writes the control and key registers while busy. A design that let the key survive the operation would accept a start with no fresh key afterwards.

// File: rtl/nvmg_pkg.sv
package nvmg_pkg;
  localparam int DW = 8;
  localparam logic [DW-1:0] KEY_FIRST  = 8'h55;
  localparam logic [DW-1:0] KEY_SECOND = 8'hAA;

  localparam int CTRL_GO     = 0;
  localparam int CTRL_ARM    = 1;
  localparam int CTRL_ERR    = 2;
  localparam int CTRL_OP_LSB = 3;
  localparam int OP_W        = 3;

  typedef enum logic [1:0] {KEY_IDLE, KEY_HALF, KEY_FULL} key_st_e;

  typedef enum logic [OP_W-1:0] {
    OP_ROW_ERASE   = 3'd0,
    OP_LATCH_LOAD  = 3'd1,
    OP_PROG_COMMIT = 3'd2,
    OP_UID_COMMIT  = 3'd3,
    OP_EE_WRITE    = 3'd4
  } op_e;

  function automatic int unsigned max_of(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/nvmg_key_fsm.sv
module nvmg_key_fsm
  import nvmg_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          key_hit_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          busy_i,
  output logic          armed_o
);
  key_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (busy_i) begin
      st_d = KEY_IDLE;
    end else if (wr_i) begin
      if (!key_hit_i)                                   st_d = KEY_IDLE;
      else if (wdata_i == KEY_FIRST)                    st_d = KEY_HALF;
      else if (wdata_i == KEY_SECOND && st_q == KEY_HALF) st_d = KEY_FULL;
      else                                              st_d = KEY_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= KEY_IDLE;
    else         st_q <= st_d;
  end

  assign armed_o = (st_q == KEY_FULL);

  a_r3_full_after_second: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_o) |-> $past(wr_i && key_hit_i && wdata_i == KEY_SECOND));
  a_r8_busy_empties_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !armed_o);
  a_r10_foreign_write_breaks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !key_hit_i) |=> !armed_o);
endmodule

// File: rtl/nvmg_op_len.sv
module nvmg_op_len
  import nvmg_pkg::*;
#(
  parameter int unsigned T_ROW_ERASE   = 48,
  parameter int unsigned T_LATCH_LOAD  = 2,
  parameter int unsigned T_PROG_COMMIT = 32,
  parameter int unsigned T_UID_COMMIT  = 32,
  parameter int unsigned T_EE_WRITE    = 16,
  parameter int          CNT_W         = 6
) (
  input  logic [OP_W-1:0]  code_i,
  output logic [CNT_W-1:0] len_o,
  output logic             legal_o
);
  always_comb begin
    legal_o = 1'b1;
    unique case (code_i)
      OP_ROW_ERASE:   len_o = CNT_W'(T_ROW_ERASE);
      OP_LATCH_LOAD:  len_o = CNT_W'(T_LATCH_LOAD);
      OP_PROG_COMMIT: len_o = CNT_W'(T_PROG_COMMIT);
      OP_UID_COMMIT:  len_o = CNT_W'(T_UID_COMMIT);
      OP_EE_WRITE:    len_o = CNT_W'(T_EE_WRITE);
      default: begin
        len_o   = '0;
        legal_o = 1'b0;
      end
    endcase
  end

  initial begin
    a_r7_lengths_nonzero: assert (T_ROW_ERASE > 0 && T_LATCH_LOAD > 0 && T_PROG_COMMIT > 0
                                  && T_UID_COMMIT > 0 && T_EE_WRITE > 0);
  end
endmodule

// File: rtl/nvmg_op_timer.sv
module nvmg_op_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !busy_o) begin
        busy_o <= 1'b1;
        cnt_q  <= len_i - 1'b1;
      end else if (busy_o) begin
        if (cnt_q == '0) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  a_r7_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  a_r7_start_sets_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  a_r7_len_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (len_i != '0));
endmodule

// File: rtl/nvm_unlock_guard.sv
module nvm_unlock_guard
  import nvmg_pkg::*;
#(
  parameter int          ADDR_W        = 2,
  parameter int unsigned T_ROW_ERASE   = 48,
  parameter int unsigned T_LATCH_LOAD  = 2,
  parameter int unsigned T_PROG_COMMIT = 32,
  parameter int unsigned T_UID_COMMIT  = 32,
  parameter int unsigned T_EE_WRITE    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              stall_o,
  output logic              done_o,
  output logic [OP_W-1:0]   active_op_o
);
  localparam int unsigned T_MAX = max_of(max_of(max_of(T_ROW_ERASE, T_LATCH_LOAD),
                                  max_of(T_PROG_COMMIT, T_UID_COMMIT)), T_EE_WRITE);
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_KEY  = ADDR_W'(1);

  logic            busy, armed, op_legal;
  logic            arm_q, err_q;
  logic [OP_W-1:0] op_q;
  logic [CNT_W-1:0] op_len;
  logic [OP_W-1:0] req_op;
  logic            ctrl_wr, go_req, launch, reject;

  assign req_op  = bus_wdata_i[CTRL_OP_LSB +: OP_W];
  assign ctrl_wr = bus_wr_i && (bus_addr_i == ADDR_CTRL) && !busy;
  assign go_req  = ctrl_wr && bus_wdata_i[CTRL_GO];
  // stored arm bit, not the one in this write
  assign launch  = go_req && armed && arm_q && op_legal;
  assign reject  = go_req && !launch;

  nvmg_key_fsm u_key (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (bus_wr_i),
    .key_hit_i (bus_addr_i == ADDR_KEY),
    .wdata_i   (bus_wdata_i),
    .busy_i    (busy),
    .armed_o   (armed)
  );

  nvmg_op_len #(
    .T_ROW_ERASE   (T_ROW_ERASE),
    .T_LATCH_LOAD  (T_LATCH_LOAD),
    .T_PROG_COMMIT (T_PROG_COMMIT),
    .T_UID_COMMIT  (T_UID_COMMIT),
    .T_EE_WRITE    (T_EE_WRITE),
    .CNT_W         (CNT_W)
  ) u_len (
    .code_i  (req_op),
    .len_o   (op_len),
    .legal_o (op_legal)
  );

  nvmg_op_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (launch),
    .len_i   (op_len),
    .busy_o  (busy),
    .done_o  (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q <= 1'b0;
      err_q <= 1'b0;
      op_q  <= '0;
    end else if (ctrl_wr) begin
      arm_q <= bus_wdata_i[CTRL_ARM];
      op_q  <= req_op;
      err_q <= reject | (err_q & bus_wdata_i[CTRL_ERR]);
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_CTRL) begin
      rd_data_o[CTRL_GO]                  = busy;
      rd_data_o[CTRL_ARM]                 = arm_q;
      rd_data_o[CTRL_ERR]                 = err_q;
      rd_data_o[CTRL_OP_LSB +: OP_W]      = op_q;
    end
  end

  assign stall_o     = busy;
  assign active_op_o = busy ? op_q : '0;

  a_r2_stall_needs_go: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> $past(bus_wr_i && bus_addr_i == ADDR_CTRL && bus_wdata_i[CTRL_GO]));
  a_r4_stall_needs_prior_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> $past(arm_q));
  a_r6_running_op_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (active_op_o <= OP_EE_WRITE));
  a_r5_err_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_q) |-> $past(bus_wr_i && bus_addr_i == ADDR_CTRL && bus_wdata_i[CTRL_GO]));
  a_r8_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && $past(stall_o)) |-> ($stable(arm_q) && $stable(op_q) && $stable(err_q)));
endmodule

// File: tb/nvm_unlock_guard_tb_top.sv
module nvm_unlock_guard_tb_top;
  localparam int TE = 7, TL = 1, TP = 5, TU = 4, TW = 3;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [1:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic       stall, done;
  logic [2:0] active_op;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  nvm_unlock_guard #(.ADDR_W(2), .T_ROW_ERASE(TE), .T_LATCH_LOAD(TL),
    .T_PROG_COMMIT(TP), .T_UID_COMMIT(TU), .T_EE_WRITE(TW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .stall_o(stall), .done_o(done), .active_op_o(active_op));

  function automatic int dur(int op);
    case (op)
      0: return TE; 1: return TL; 2: return TP; 3: return TU; 4: return TW;
      default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_ctrl(output logic [7:0] v);
    rd_addr = 0;
    #1 v = rd_data;
  endtask

  // returns stall length and whether done was seen when stall dropped
  task automatic measure(output int n, output bit d, output logic [2:0] first_op);
    n = 0;
    #1 first_op = active_op;
    while (stall && n < 1000) begin
      n++;
      @(negedge clk);
      #1;
    end
    d = done;
  endtask

  task automatic expect_launch(int op, string req);
    int n; bit d; logic [2:0] fo; logic [7:0] v;
    #1;
    chk(stall === 1'b1, req, stall, 1);
    rd_ctrl(v);
    chk(v[0] === 1'b1, {req, " go bit busy"}, v[0], 1);
    measure(n, d, fo);
    chk(n == dur(op), {req, " R7 stall length"}, n, dur(op));
    chk(d === 1'b1, {req, " R7 done pulse"}, d, 1);
    chk(fo == 3'(op), {req, " R9 active op"}, fo, op);
    @(negedge clk); #1;
    chk(done === 1'b0 && active_op == 0, {req, " R7 done one cycle"}, done, 0);
    rd_ctrl(v);
    chk(v[0] === 1'b0, {req, " R7 go cleared"}, v[0], 0);
  endtask

  task automatic expect_reject(string req);
    logic [7:0] v;
    #1;
    chk(stall === 1'b0, req, stall, 0);
    rd_ctrl(v);
    chk(v[2:0] == 3'b010 || v[2:0] == 3'b100 || v[2:0] == 3'b110,
        {req, " R5 go0 err1"}, v[2:0], 3'b110);
    chk(v[2] === 1'b1, {req, " R5 err flag"}, v[2], 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    #1;
    rd_ctrl(v);
    chk(v == 8'h00, "R1 ctrl reset", v, 0);
    chk(stall === 0 && done === 0 && active_op == 0, "R1 outputs reset", {stall, done}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R6 R7 R9: all op codes
    for (int op = 0; op < 8; op++) begin
      wr(0, 8'(op << 3) | 8'h02);
      wr(1, 8'h55); wr(1, 8'hAA);
      wr(0, 8'(op << 3) | 8'h03);
      if (op <= 4) expect_launch(op, "R2 op sweep");
      else expect_reject("R6 illegal op");
    end

    // R3 second key byte sweep
    for (int k = 0; k < 256; k++) begin
      wr(0, 8'h0A);
      wr(1, 8'h55); wr(1, 8'(k));
      wr(0, 8'h0B);
      if (k == 8'hAA) expect_launch(1, "R3 second byte");
      else expect_reject("R3 second byte");
    end

    // R3 first key byte sweep
    for (int k = 0; k < 256; k++) begin
      wr(0, 8'h0A);
      wr(1, 8'(k)); wr(1, 8'hAA);
      wr(0, 8'h0B);
      if (k == 8'h55) expect_launch(1, "R3 first byte");
      else expect_reject("R3 first byte");
    end

    // R3 repeated first byte restarts
    wr(0, 8'h0A);
    wr(1, 8'h55); wr(1, 8'h55); wr(1, 8'hAA);
    wr(0, 8'h0B);
    expect_launch(1, "R3 repeated 0x55");

    // R10 intruding writes at both points
    for (int p = 0; p < 2; p++) begin
      for (int kind = 0; kind < 4; kind++) begin
        wr(0, 8'h0A);
        wr(1, 8'h55);
        if (p == 1) wr(1, 8'hAA);
        case (kind)
          0: wr(2, 8'h00);
          1: wr(3, 8'hAA);
          2: wr(0, 8'h0A);
          default: wr(1, 8'h00);
        endcase
        if (p == 0) wr(1, 8'hAA);
        wr(0, 8'h0B);
        expect_reject("R10 intruder");
      end
    end

    // R10 idle gaps keep the chain
    wr(0, 8'h12);
    repeat (5) @(negedge clk);
    wr(1, 8'h55);
    repeat (7) @(negedge clk);
    wr(1, 8'hAA);
    repeat (3) @(negedge clk);
    wr(0, 8'h13);
    expect_launch(2, "R10 idle gaps");

    // R4 arm and start in one write
    wr(0, 8'h00);
    wr(1, 8'h55); wr(1, 8'hAA);
    wr(0, 8'h03);
    expect_reject("R4 same-write arm");
    rd_ctrl(v);
    chk(v[1] === 1'b1, "R4 arm stored", v[1], 1);

    // R5 error flag hold and clear
    wr(0, 8'h06);
    rd_ctrl(v);
    chk(v[2] === 1'b1, "R5 err held with bit2", v[2], 1);
    wr(0, 8'h02);
    rd_ctrl(v);
    chk(v[2] === 1'b0, "R5 err cleared", v[2], 0);

    // R8 writes while busy
    wr(0, 8'h02);
    wr(1, 8'h55); wr(1, 8'hAA);
    wr(0, 8'h03);
    #1;
    chk(stall === 1'b1, "R8 erase launched", stall, 1);
    @(negedge clk); bus_wr = 1; bus_addr = 0; bus_wdata = 8'h0C;
    @(negedge clk); bus_addr = 1; bus_wdata = 8'h55;
    @(negedge clk); bus_wdata = 8'hAA;
    @(negedge clk); bus_wr = 0;
    while (stall) @(negedge clk);
    #1;
    rd_ctrl(v);
    chk(v == 8'h02, "R8 ctrl unchanged", v, 8'h02);
    wr(0, 8'h03);
    expect_reject("R8 key emptied");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule